// File: doc/BRIEF.md
# SRAM Bus Front-End with Power-Fail Lockout

This block is a clocked model of an asynchronous byte-wide static RAM port. The host presents active-low chip-select, output-enable and write-strobe lines, an address and a data byte. The block brings these into the system clock domain and finds read and write cycles in them. A byte is stored only when both chip-select and write-strobe have been low together and that overlap has ended. The data bus is split into a data-in byte, a data-out byte and a drive-enable flag. A board-level wrapper combines these three into a tristate bus.

A power-fail input locks the port. While it is high, no byte is stored, no cycle is reported and the bus is not driven. A cycle that saw power-fail at any point while its strobes were active is discarded, even if power-fail has dropped by the time the cycle ends.

For every cycle that completes cleanly, the block raises a one-clock read or write event. The write event carries data bit 0. A downstream sequencer of side-channel registers listens to these events. While that sequencer owns the bus, it raises a memory-inhibit input, and the array is neither written nor read.

Top module: `sfe_sram_front`

## Requirements
- R1: After reset, `dq_oe`, `ev_read`, `ev_write` and `ev_bit` are all 0.
- R2: With chip-select low, write-strobe high and output-enable low, `dq_out` shows the stored byte at `addr`, SYNC_STAGES clocks after the inputs are sampled.
- R3: A byte is stored only for an overlap of chip-select low and write-strobe low. It is stored when the first of the two strobes rises, with the address and data held during the last overlap clock. Either strobe may fall first.
- R4: `dq_oe` is 1 only while the synchronized chip-select and output-enable are low and the synchronized write-strobe is high. A falling write-strobe clears it.
- R5: Each cleanly closed read window (chip-select low, write-strobe high) gives exactly one `ev_read` pulse. Each closed write overlap gives exactly one `ev_write` pulse, and `ev_bit` equals data bit 0 of that write. Both pulses appear one clock after the closing edge is seen, and the two are never high together.
- R6: While `power_fail` is 1, `dq_oe` is 0. A window during which `power_fail` was 1 on any clock, or on its closing clock, stores nothing and raises no event.
- R7: After `power_fail` returns to 0, a fresh cycle reads and writes normally.
- R8: While `mem_inhibit` is 1, a closing write stores nothing but still raises its event, and `dq_out` reads 0x00 while driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Active-low chip-select |
| oe_n | input | 1 | Active-low output-enable |
| we_n | input | 1 | Active-low write-strobe |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from the bus |
| power_fail | input | 1 | Lockout request; blocks all access while high |
| mem_inhibit | input | 1 | Blocks array write and read data while high |
| dq_out | output | DATA_W | Read data toward the bus |
| dq_oe | output | 1 | Drive enable for the data bus |
| ev_read | output | 1 | One-clock pulse per completed read cycle |
| ev_write | output | 1 | One-clock pulse per completed write cycle |
| ev_bit | output | 1 | Data bit 0 of the write reported on `ev_write` |

## Verification
The bench builds the block with the full 13-bit address and 8-bit data. This makes the top address 0x1FFF and address 0x0000 both usable as write targets. It sets SYNC_STAGES to 3 rather than the default 2, so the read latency and event timing are checked against a synchronizer depth other than the default. It also covers both strobe orders for opening and closing a write. A power-fail pulse placed inside an open write overlap checks that the cycle is discarded after the pulse has gone.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // Index of each cycle kind in the window-tracker array
  localparam int unsigned KIND_RD = 0;
  localparam int unsigned KIND_WR = 1;
  localparam int unsigned N_KINDS = 2;
  localparam int unsigned N_STROBES = 3;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stg_d;
      if (i == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfe_window.sv
module sfe_window (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic pfail_i,
  output logic done_o
);
  logic open_q, taint_q;
  logic taint_d;

  always_comb begin
    taint_d = open_i ? (taint_q | pfail_i) : 1'b0;
    done_o  = open_q & ~open_i & ~pfail_i & ~taint_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      taint_q <= 1'b0;
    end else begin
      open_q  <= open_i;
      taint_q <= taint_d;
    end
  end

  AST_TAINT_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> !taint_q); // R6
endmodule

// File: rtl/sfe_array.sv
module sfe_array #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sfe_sram_front.sv
module sfe_sram_front #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              power_fail,
  input  logic              mem_inhibit,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ev_read,
  output logic              ev_write,
  output logic              ev_bit
);
  import sfe_pkg::*;

  localparam int unsigned BUS_W = N_STROBES + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {{N_STROBES{1'b1}}, {(ADDR_W+DATA_W){1'b0}}};

  // Reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // Strobes, address and data move together through the synchronizer
  logic [BUS_W-1:0]  bus_s;
  logic              ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  sfe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_core_n),
    .d_i({ce_n, oe_n, we_n, addr, dq_in}), .q_o(bus_s));
  assign {ce_s, oe_s, we_s, addr_s, din_s} = bus_s;

  // Window tracking for read and write cycles
  logic [N_KINDS-1:0] win_open, win_done;
  assign win_open[KIND_RD] = ~ce_s &  we_s;
  assign win_open[KIND_WR] = ~ce_s & ~we_s;

  generate
    for (genvar k = 0; k < N_KINDS; k++) begin : g_win
      sfe_window u_win (
        .clk(clk), .rst_n(rst_core_n),
        .open_i(win_open[k]), .pfail_i(power_fail), .done_o(win_done[k]));
    end
  endgenerate

  // Address and data from the last clock of an open write overlap
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              cap_en;

  always_comb begin
    cap_en = win_open[KIND_WR];
    wa_d   = cap_en ? addr_s : wa_q;
    wd_d   = cap_en ? din_s  : wd_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wa_q <= wa_d;
      wd_q <= wd_d;
    end
  end

  // Array
  logic              arr_we;
  logic [DATA_W-1:0] arr_rd;
  assign arr_we = win_done[KIND_WR] & ~mem_inhibit;

  sfe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(arr_we), .wr_addr(wa_q), .wr_data(wd_q),
    .rd_addr(addr_s), .rd_data(arr_rd));

  // Events
  logic ev_read_d, ev_write_d, ev_bit_d;
  always_comb begin
    ev_read_d  = win_done[KIND_RD];
    ev_write_d = win_done[KIND_WR];
    ev_bit_d   = win_done[KIND_WR] & wd_q[0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ev_read  <= 1'b0;
      ev_write <= 1'b0;
      ev_bit   <= 1'b0;
    end else begin
      ev_read  <= ev_read_d;
      ev_write <= ev_write_d;
      ev_bit   <= ev_bit_d;
    end
  end

  // Bus drive
  always_comb begin
    dq_oe  = ~power_fail & ~ce_s & ~oe_s & we_s;
    dq_out = (power_fail | mem_inhibit) ? '0 : arr_rd;
  end

  AST_HIZ_IN_PFAIL: assert property (@(posedge clk) disable iff (!rst_core_n)
    power_fail |-> !dq_oe); // R6
  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    dq_oe |-> !win_open[KIND_WR]); // R4
  AST_EV_MUTEX: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(ev_read && ev_write)); // R5
  AST_EV_SINGLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ev_write |=> !ev_write); // R5
  AST_NO_EV_AFTER_PFAIL: assert property (@(posedge clk) disable iff (!rst_core_n)
    ev_write |-> !$past(power_fail)); // R6
  AST_BIT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ev_bit |-> ev_write); // R5
endmodule

// File: tb/sfe_sram_front_tb.sv
module sfe_sram_front_tb_top;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int SY = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, ce_n, oe_n, we_n, power_fail, mem_inhibit;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe, ev_read, ev_write, ev_bit;

  sfe_sram_front #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .power_fail(power_fail), .mem_inhibit(mem_inhibit),
    .dq_out(dq_out), .dq_oe(dq_oe), .ev_read(ev_read), .ev_write(ev_write), .ev_bit(ev_bit));

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit chk_en = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: queue delay for the synchronizer, then window bookkeeping
  typedef struct { bit ce, oe, we; int a; int d; } snap_t;
  snap_t q[$];
  snap_t sy;
  logic [7:0] mmem [int];
  bit m_ev_r, m_ev_w, m_ev_b;
  bit w_open, w_bad, r_open, r_bad;
  int w_a, w_d;

  function automatic snap_t idle_snap();
    snap_t s;
    s.ce = 1; s.oe = 1; s.we = 1; s.a = 0; s.d = 0;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < SY - 1; i++) q.push_back(idle_snap());
      sy = idle_snap();
      m_ev_r = 0; m_ev_w = 0; m_ev_b = 0;
      w_open = 0; w_bad = 0; r_open = 0; r_bad = 0;
      w_a = 0; w_d = 0;
    end else begin
      bit wo, ro;
      snap_t s;
      wo = !sy.ce && !sy.we;
      ro = !sy.ce && sy.we;
      m_ev_w = w_open && !wo && !power_fail && !w_bad;
      m_ev_b = m_ev_w && w_d[0];
      if (m_ev_w && !mem_inhibit) mmem[w_a] = w_d[7:0];
      m_ev_r = r_open && !ro && !power_fail && !r_bad;
      w_bad = wo ? (w_bad | power_fail) : 1'b0;
      r_bad = ro ? (r_bad | power_fail) : 1'b0;
      if (wo) begin w_a = sy.a; w_d = sy.d; end
      w_open = wo;
      r_open = ro;
      s.ce = ce_n; s.oe = oe_n; s.we = we_n; s.a = int'(addr); s.d = int'(dq_in);
      q.push_back(s);
      sy = q.pop_front();
    end
  end

  // Comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      bit exp_oe;
      exp_oe = !power_fail && !sy.ce && !sy.oe && sy.we;
      check(cur_req, "dq_oe (R4)", int'(dq_oe), int'(exp_oe));
      if (exp_oe && mem_inhibit)
        check(cur_req, "dq_out inhibited (R8)", int'(dq_out), 0);
      else if (exp_oe && mmem.exists(sy.a))
        check(cur_req, "dq_out (R2)", int'(dq_out), int'(mmem[sy.a]));
      check(cur_req, "ev_read (R5)", int'(ev_read), int'(m_ev_r));
      check(cur_req, "ev_write (R5)", int'(ev_write), int'(m_ev_w));
      check(cur_req, "ev_bit (R5)", int'(ev_bit), int'(m_ev_b));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // order 0: ce falls first, we rises first; order 1: we falls first, ce rises first
  task automatic wr(input int a, input int d, input bit order);
    addr = AW'(a); dq_in = DW'(d);
    if (!order) begin
      ce_n = 0; step(2); we_n = 0; step(3); we_n = 1; step(2); ce_n = 1; step(SY + 2);
    end else begin
      we_n = 0; step(2); ce_n = 0; step(3); ce_n = 1; step(2); we_n = 1; step(SY + 2);
    end
  endtask

  task automatic rd_expect(input int a, input int exp, input string req);
    addr = AW'(a); ce_n = 0; oe_n = 0;
    step(SY);
    @(negedge clk);
    check(req, "directed dq_oe", int'(dq_oe), 1);
    check(req, "directed dq_out", int'(dq_out), exp);
    step(1);
    ce_n = 1; oe_n = 1; step(SY + 2);
  endtask

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; dq_in = '0;
    power_fail = 0; mem_inhibit = 0;
    step(3);
    rst_n = 1;
    step(4);
    @(negedge clk);
    check("R1", "reset dq_oe", int'(dq_oe), 0);
    check("R1", "reset ev_read", int'(ev_read), 0);
    check("R1", "reset ev_write", int'(ev_write), 0);
    check("R1", "reset ev_bit", int'(ev_bit), 0);
    chk_en = 1;
    step(1);

    cur_req = "R3";
    wr('h0123, 'hA5, 0);
    wr('h1FFF, 'h3C, 1);
    wr('h0000, 'h01, 0);
    wr('h0040, 'h11, 1);

    cur_req = "R2";
    rd_expect('h0123, 'hA5, "R2");
    rd_expect('h1FFF, 'h3C, "R2");
    rd_expect('h0000, 'h01, "R3");

    cur_req = "R4";
    addr = 'h0123; ce_n = 0; step(SY + 1);
    @(negedge clk);
    check("R4", "oe high keeps bus off", int'(dq_oe), 0);
    step(1);
    oe_n = 0; step(SY + 1);
    we_n = 0; dq_in = 'hA5; step(SY);
    @(negedge clk);
    check("R4", "falling we turns bus off", int'(dq_oe), 0);
    step(1);
    we_n = 1; step(1); ce_n = 1; oe_n = 1; step(SY + 3);

    cur_req = "R5";
    addr = 'h0123; ce_n = 0; dq_in = 'h00; step(4); ce_n = 1; step(SY + 3);
    rd_expect('h0123, 'hA5, "R5");

    cur_req = "R6";
    power_fail = 1;
    wr('h0123, 'hFF, 0);
    addr = 'h0123; ce_n = 0; oe_n = 0; step(SY + 1);
    @(negedge clk);
    check("R6", "bus off in power fail", int'(dq_oe), 0);
    step(1); ce_n = 1; oe_n = 1; step(SY + 1);
    power_fail = 0; step(2);
    addr = 'h1FFF; dq_in = 'h00; ce_n = 0; we_n = 0; step(SY + 1);
    power_fail = 1; step(1); power_fail = 0; step(2);
    we_n = 1; ce_n = 1; step(SY + 3);

    cur_req = "R7";
    rd_expect('h0123, 'hA5, "R6");
    rd_expect('h1FFF, 'h3C, "R6");
    wr('h0123, 'h5A, 1);
    rd_expect('h0123, 'h5A, "R7");

    cur_req = "R8";
    mem_inhibit = 1;
    wr('h0040, 'h77, 0);
    rd_expect('h0040, 'h00, "R8");
    mem_inhibit = 0;
    rd_expect('h0040, 'h11, "R8");

    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R1) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule